// File: doc/BRIEF.md
# Multi-Master Doorbell Interrupt Unit

The block holds a small array of doorbells. Each doorbell belongs to one receiving master and can be rung by any master on the shared register bus. Every bus request carries the numeric ID of the master that issued it. When a master writes the value 1 to a doorbell's ring word, the bit for that master is set in the doorbell's raw word. If the receiver has set the same bit in its sender-enable word, the bit is also set in the pending word. The receiver reads the pending word to learn which senders rang, and writes that value back to clear those bits. Each doorbell drives one level interrupt that stays high while any pending bit is set.

The bus has several request ports, so several masters can reach the unit in the same cycle. Rings arriving together are merged. Clears are merged. When two ports write the same enable word in one cycle, the lower-numbered port wins. When a ring and a clear hit the same pending or raw bit in the same cycle, the ring wins. Each doorbell occupies a 256-byte window. Address bits from 8 upward select the doorbell, and the low byte selects the word. Read data is registered and returns one cycle after the request.

Top module: `db_ring_unit`

## Requirements
- R1: After reset, the enable, raw and pending words of every doorbell read as zero and every interrupt output is low.
- R2: A write to offset 0x4 of a doorbell stores the written value as that doorbell's sender-enable mask (bit M = master M allowed), and a read of offset 0x4 returns it.
- R3: A write of exactly 1 to offset 0x0 of doorbell k from master M sets bit M of doorbell k's raw word (offset 0x8). The other bits of that word and the other doorbells are unchanged.
- R4: A ring from master M sets bit M of the pending word (offset 0xC) only if bit M of that doorbell's enable word was set in the cycle of the ring.
- R5: A write to offset 0x0 with any value other than 1 changes no register.
- R6: A write to offset 0xC clears each pending bit written as 1 and leaves the bits written as 0 unchanged.
- R7: A write to offset 0x8 clears each raw bit written as 1 and leaves the bits written as 0 unchanged.
- R8: If a ring and a clear target the same raw or pending bit in the same cycle, the ring wins and the bit is set afterwards.
- R9: Interrupt output k is high exactly when doorbell k's pending word is nonzero. It follows the register one cycle after the request edge.
- R10: Every read gives rsp_valid and data one cycle after the request. A read of offset 0x0, of offsets 0x10 and above, or of a non-word-aligned address returns 0. Writes to those extra or misaligned offsets change nothing.
- R11: If two ports write the same enable word in the same cycle, the value from the lower-numbered port is kept.
- R12: A read returns the register value from before any write accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | N_PORT | Request present, one bit per port |
| req_write | input | N_PORT | 1 = write, 0 = read, per port |
| req_addr | input | N_PORT*AW | Byte address per port: doorbell index above bit 8, word in low byte |
| req_wdata | input | N_PORT*32 | Write data per port |
| req_mid | input | N_PORT*MID_W | Issuing master ID per port |
| rsp_valid | output | N_PORT | Read data valid, one cycle after a read |
| rsp_rdata | output | N_PORT*32 | Read data per port |
| irq | output | N_DB | Level interrupt per doorbell |

## Verification
The assertions assume that every master ID on req_mid is below N_MASTER. They also assume that each request holds its fields stable only within its single cycle. No multi-cycle request is assumed. The enable-priority property assumes port 0 is the highest-priority writer. The stimulus picks master IDs only from 0 to N_MASTER-1, drives every request for exactly one cycle, and mixes same-cycle collisions between the two ports. These collisions include ring against clear, enable against enable, and read against write to one doorbell. A weighted choice of offsets keeps rings frequent, so pending bits build up and are cleared often.

// File: rtl/db_pkg.sv
package db_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    REG_RING = 3'd0,
    REG_EN   = 3'd1,
    REG_RAW  = 3'd2,
    REG_PEND = 3'd3,
    REG_NONE = 3'd4
  } db_reg_e;

  // Low byte of the window -> register selector.
  function automatic db_reg_e word_select(input logic [7:0] low_byte);
    db_reg_e sel;
    if ((low_byte[1:0] != 2'b00) || (low_byte[7:4] != 4'h0)) begin
      sel = REG_NONE;
    end else begin
      case (low_byte[3:2])
        2'd0:    sel = REG_RING;
        2'd1:    sel = REG_EN;
        2'd2:    sel = REG_RAW;
        default: sel = REG_PEND;
      endcase
    end
    return sel;
  endfunction

endpackage

// File: rtl/db_rst_sync.sv
module db_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/db_port_decode.sv
module db_port_decode #(
  parameter int N_DB  = 4,
  parameter int DBI_W = 2,
  parameter int AW    = 10
) (
  input  logic                 valid,
  input  logic                 write,
  input  logic [AW-1:0]        addr,
  output logic [N_DB-1:0]      cell_sel,
  output logic [DBI_W-1:0]     cell_idx,
  output db_pkg::db_reg_e      reg_sel,
  output logic                 is_write,
  output logic                 is_read
);

  always_comb begin
    cell_idx = addr[AW-1:8];
    reg_sel  = db_pkg::word_select(addr[7:0]);
    is_write = valid & write;
    is_read  = valid & ~write;
    for (int k = 0; k < N_DB; k++) begin
      cell_sel[k] = valid && (cell_idx == DBI_W'(k));
    end
  end

endmodule

// File: rtl/db_cell.sv
module db_cell #(
  parameter int N_PORT   = 2,
  parameter int N_MASTER = 32,
  parameter int MID_W    = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [N_PORT-1:0]                  sel,
  input  logic [N_PORT-1:0]                  wr,
  input  db_pkg::db_reg_e                    reg_sel [N_PORT],
  input  logic [N_PORT-1:0][db_pkg::DATA_W-1:0] wdata,
  input  logic [N_PORT-1:0][MID_W-1:0]       mid,
  output logic [N_MASTER-1:0]                en_q,
  output logic [N_MASTER-1:0]                raw_q,
  output logic [N_MASTER-1:0]                pend_q,
  output logic                               irq_o
);

  import db_pkg::*;

  localparam logic [N_MASTER-1:0] ONE_BIT = {{(N_MASTER-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0]   RING_CODE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [N_MASTER-1:0] ring_mask;
  logic [N_MASTER-1:0] raw_clr;
  logic [N_MASTER-1:0] pend_clr;
  logic                en_wr;
  logic [N_MASTER-1:0] en_d;
  logic [N_MASTER-1:0] raw_d;
  logic [N_MASTER-1:0] pend_d;
  logic                raw_ce;
  logic                pend_ce;

  // Merge all ports; descending loop so port 0 has the last word on enable.
  always_comb begin
    ring_mask = '0;
    raw_clr   = '0;
    pend_clr  = '0;
    en_wr     = 1'b0;
    en_d      = en_q;
    for (int p = N_PORT - 1; p >= 0; p--) begin
      if (sel[p] && wr[p]) begin
        case (reg_sel[p])
          REG_RING: begin
            if (wdata[p] == RING_CODE) begin
              ring_mask = ring_mask | (ONE_BIT << mid[p]);
            end
          end
          REG_EN: begin
            en_wr = 1'b1;
            en_d  = wdata[p][N_MASTER-1:0];
          end
          REG_RAW:  raw_clr  = raw_clr  | wdata[p][N_MASTER-1:0];
          REG_PEND: pend_clr = pend_clr | wdata[p][N_MASTER-1:0];
          default: ;
        endcase
      end
    end
  end

  // Next state: ring takes precedence over same-cycle clear.
  always_comb begin
    raw_d   = (raw_q  & ~raw_clr)  | ring_mask;
    pend_d  = (pend_q & ~pend_clr) | (ring_mask & en_q);
    raw_ce  = (|ring_mask) | (|raw_clr);
    pend_ce = (|(ring_mask & en_q)) | (|pend_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      raw_q  <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr) begin
        en_q <= en_d;
      end
      if (raw_ce) begin
        raw_q <= raw_d;
      end
      if (pend_ce) begin
        pend_q <= pend_d;
      end
    end
  end

  assign irq_o = |pend_q;

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0)); // R4

  AST_RING_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ring_mask & en_q & pend_clr) != '0) |=>
      ((pend_q & $past(ring_mask & en_q & pend_clr)) == $past(ring_mask & en_q & pend_clr))); // R8

  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((ring_mask == '0) && (raw_clr == '0)) |=> $stable(raw_q)); // R7

  AST_IRQ_NEEDS_RING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ring_mask != '0)); // R9

  AST_EN_PORT0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[0] && wr[0] && (reg_sel[0] == REG_EN)) |=> (en_q == $past(wdata[0][N_MASTER-1:0]))); // R11

endmodule

// File: rtl/db_read_port.sv
module db_read_port #(
  parameter int N_DB     = 4,
  parameter int DBI_W    = 2,
  parameter int N_MASTER = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              is_read,
  input  logic [DBI_W-1:0]                  cell_idx,
  input  db_pkg::db_reg_e                   reg_sel,
  input  logic [N_DB-1:0][N_MASTER-1:0]     en_all,
  input  logic [N_DB-1:0][N_MASTER-1:0]     raw_all,
  input  logic [N_DB-1:0][N_MASTER-1:0]     pend_all,
  output logic                              rvalid_q,
  output logic [db_pkg::DATA_W-1:0]         rdata_q
);

  import db_pkg::*;

  logic [N_MASTER-1:0] word_sel;
  logic [DATA_W-1:0]   rdata_d;

  always_comb begin
    word_sel = '0;
    if (int'(cell_idx) < N_DB) begin
      case (reg_sel)
        REG_EN:   word_sel = en_all[cell_idx];
        REG_RAW:  word_sel = raw_all[cell_idx];
        REG_PEND: word_sel = pend_all[cell_idx];
        default:  word_sel = '0;
      endcase
    end
    rdata_d = DATA_W'(word_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= is_read;
      if (is_read) begin
        rdata_q <= rdata_d;
      end
    end
  end

  AST_EMPTY_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read && ((reg_sel == REG_NONE) || (reg_sel == REG_RING))) |=>
      (rvalid_q && (rdata_q == '0))); // R10

endmodule

// File: rtl/db_ring_unit.sv
module db_ring_unit #(
  parameter int N_DB     = 4,
  parameter int N_PORT   = 2,
  parameter int N_MASTER = 32,
  localparam int DBI_W   = (N_DB > 1) ? $clog2(N_DB) : 1,
  localparam int AW      = DBI_W + 8,
  localparam int MID_W   = (N_MASTER > 1) ? $clog2(N_MASTER) : 1,
  localparam int DW      = db_pkg::DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PORT-1:0]        req_valid,
  input  logic [N_PORT-1:0]        req_write,
  input  logic [N_PORT*AW-1:0]     req_addr,
  input  logic [N_PORT*DW-1:0]     req_wdata,
  input  logic [N_PORT*MID_W-1:0]  req_mid,
  output logic [N_PORT-1:0]        rsp_valid,
  output logic [N_PORT*DW-1:0]     rsp_rdata,
  output logic [N_DB-1:0]          irq
);

  import db_pkg::*;

  logic rst_sync_n;

  logic [N_PORT-1:0][N_DB-1:0]   cell_sel;
  logic [N_PORT-1:0][DBI_W-1:0]  cell_idx;
  db_reg_e                       reg_sel [N_PORT];
  logic [N_PORT-1:0]             is_write;
  logic [N_PORT-1:0]             is_read;
  logic [N_PORT-1:0][DW-1:0]     wdata_a;
  logic [N_PORT-1:0][MID_W-1:0]  mid_a;

  logic [N_DB-1:0][N_MASTER-1:0] en_all;
  logic [N_DB-1:0][N_MASTER-1:0] raw_all;
  logic [N_DB-1:0][N_MASTER-1:0] pend_all;

  db_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    assign wdata_a[p] = req_wdata[p*DW +: DW];
    assign mid_a[p]   = req_mid[p*MID_W +: MID_W];

    db_port_decode #(
      .N_DB  (N_DB),
      .DBI_W (DBI_W),
      .AW    (AW)
    ) u_dec (
      .valid    (req_valid[p]),
      .write    (req_write[p]),
      .addr     (req_addr[p*AW +: AW]),
      .cell_sel (cell_sel[p]),
      .cell_idx (cell_idx[p]),
      .reg_sel  (reg_sel[p]),
      .is_write (is_write[p]),
      .is_read  (is_read[p])
    );

    db_read_port #(
      .N_DB     (N_DB),
      .DBI_W    (DBI_W),
      .N_MASTER (N_MASTER)
    ) u_rd (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .is_read  (is_read[p]),
      .cell_idx (cell_idx[p]),
      .reg_sel  (reg_sel[p]),
      .en_all   (en_all),
      .raw_all  (raw_all),
      .pend_all (pend_all),
      .rvalid_q (rsp_valid[p]),
      .rdata_q  (rsp_rdata[p*DW +: DW])
    );
  end

  for (genvar k = 0; k < N_DB; k++) begin : g_cell
    logic [N_PORT-1:0] sel_k;

    always_comb begin
      for (int p = 0; p < N_PORT; p++) begin
        sel_k[p] = cell_sel[p][k];
      end
    end

    db_cell #(
      .N_PORT   (N_PORT),
      .N_MASTER (N_MASTER),
      .MID_W    (MID_W)
    ) u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .sel     (sel_k),
      .wr      (is_write),
      .reg_sel (reg_sel),
      .wdata   (wdata_a),
      .mid     (mid_a),
      .en_q    (en_all[k]),
      .raw_q   (raw_all[k]),
      .pend_q  (pend_all[k]),
      .irq_o   (irq[k])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    (!rst_sync_n) |-> (irq == '0)); // R1

endmodule

// File: tb/db_ring_unit_test.sv
`timescale 1ns/1ps
module db_ring_unit_test;

  localparam int NDB = 4;
  localparam int NP  = 2;
  localparam int NM  = 32;
  localparam int AW  = 10;
  localparam int MW  = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP-1:0]     req_valid;
  logic [NP-1:0]     req_write;
  logic [NP*AW-1:0]  req_addr;
  logic [NP*32-1:0]  req_wdata;
  logic [NP*MW-1:0]  req_mid;
  logic [NP-1:0]     rsp_valid;
  logic [NP*32-1:0]  rsp_rdata;
  logic [NDB-1:0]    irq;

  logic              p_v [NP];
  logic              p_w [NP];
  logic [AW-1:0]     p_a [NP];
  logic [31:0]       p_d [NP];
  logic [MW-1:0]     p_m [NP];

  logic [31:0] m_en   [NDB];
  logic [31:0] m_raw  [NDB];
  logic [31:0] m_pend [NDB];

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  db_ring_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mid   (req_mid),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq       (irq)
  );

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      req_valid[p]          = p_v[p];
      req_write[p]          = p_w[p];
      req_addr[p*AW +: AW]  = p_a[p];
      req_wdata[p*32 +: 32] = p_d[p];
      req_mid[p*MW +: MW]   = p_m[p];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Expected read value per R2, R3, R6, R10 address layout.
  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    logic [1:0] k;
    k = a[9:8];
    if (a[1:0] != 2'b00 || a[7:4] != 4'h0) return 32'h0;
    case (a[3:2])
      2'd1:    return m_en[k];
      2'd2:    return m_raw[k];
      2'd3:    return m_pend[k];
      default: return 32'h0;
    endcase
  endfunction

  // Next model state from the requirements (R3..R8, R11).
  task automatic model_apply();
    logic [31:0] ring [NDB];
    logic [31:0] rclr [NDB];
    logic [31:0] pclr [NDB];
    logic [31:0] en_n [NDB];
    for (int k = 0; k < NDB; k++) begin
      ring[k] = 0; rclr[k] = 0; pclr[k] = 0; en_n[k] = m_en[k];
    end
    for (int p = NP - 1; p >= 0; p--) begin
      if (p_v[p] && p_w[p] && p_a[p][1:0] == 2'b00 && p_a[p][7:4] == 4'h0) begin
        case (p_a[p][3:2])
          2'd0: if (p_d[p] == 32'd1) ring[p_a[p][9:8]] |= (32'd1 << p_m[p]);
          2'd1: en_n[p_a[p][9:8]] = p_d[p];
          2'd2: rclr[p_a[p][9:8]] |= p_d[p];
          default: pclr[p_a[p][9:8]] |= p_d[p];
        endcase
      end
    end
    for (int k = 0; k < NDB; k++) begin
      m_pend[k] = (m_pend[k] & ~pclr[k]) | (ring[k] & m_en[k]);
      m_raw[k]  = (m_raw[k]  & ~rclr[k]) | ring[k];
      m_en[k]   = en_n[k];
    end
  endtask

  task automatic idle();
    for (int p = 0; p < NP; p++) begin
      p_v[p] = 0; p_w[p] = 0; p_a[p] = '0; p_d[p] = '0; p_m[p] = '0;
    end
  endtask

  task automatic set_port(input int p, input logic w, input logic [1:0] k,
                          input logic [7:0] off, input logic [31:0] d, input logic [MW-1:0] m);
    p_v[p] = 1'b1; p_w[p] = w; p_a[p] = {k, off}; p_d[p] = d; p_m[p] = m;
  endtask

  // One cycle: inputs set at negedge, outputs sampled at the following negedge.
  task automatic step(input string tag);
    logic [31:0] exp_rd [NP];
    logic        rd_chk [NP];
    for (int p = 0; p < NP; p++) begin
      rd_chk[p] = p_v[p] && !p_w[p];
      exp_rd[p] = model_read(p_a[p]);   // R12: old value
    end
    model_apply();
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      if (rd_chk[p]) begin
        check({tag, " R10 rsp_valid"}, {31'h0, rsp_valid[p]}, 32'h1);
        check(tag, rsp_rdata[p*32 +: 32], exp_rd[p]);
      end
    end
    for (int k = 0; k < NDB; k++) begin
      check("R9 irq level", {31'h0, irq[k]}, {31'h0, |m_pend[k]});
    end
    idle();
  endtask

  task automatic rd(input string tag, input logic [1:0] k, input logic [7:0] off);
    set_port(0, 1'b0, k, off, 32'h0, '0);
    step(tag);
  endtask

  task automatic wr(input string tag, input logic [1:0] k, input logic [7:0] off,
                    input logic [31:0] d, input logic [MW-1:0] m);
    set_port(0, 1'b1, k, off, d, m);
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    for (int k = 0; k < NDB; k++) begin
      m_en[k] = 0; m_raw[k] = 0; m_pend[k] = 0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {28'h0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: all words zero after reset
    for (int k = 0; k < NDB; k++) begin
      rd("R1 enable reset", 2'(k), 8'h04);
      rd("R1 raw reset",    2'(k), 8'h08);
      rd("R1 pend reset",   2'(k), 8'h0C);
    end
    check("R1 irq after reset", {28'h0, irq}, 32'h0);

    // R2: enable write and read back
    wr("R2 enable write", 2'd2, 8'h04, 32'hA5A5_0F0F, 5'd0);
    rd("R2 enable readback", 2'd2, 8'h04);
    check("R2 enable literal", rsp_rdata[31:0], 32'hA5A5_0F0F);

    // R3 / R4: ring with and without enable
    wr("R4 enable bit3", 2'd1, 8'h04, 32'h0000_0008, 5'd0);
    wr("R3 ring m3", 2'd1, 8'h00, 32'd1, 5'd3);
    check("R4 irq after enabled ring", {31'h0, irq[1]}, 32'h1);
    wr("R4 ring m7 disabled", 2'd1, 8'h00, 32'd1, 5'd7);
    rd("R3 raw two senders", 2'd1, 8'h08);
    check("R3 raw literal", rsp_rdata[31:0], 32'h0000_0088);
    rd("R4 pend only enabled", 2'd1, 8'h0C);
    check("R4 pend literal", rsp_rdata[31:0], 32'h0000_0008);
    rd("R3 other doorbell raw", 2'd0, 8'h08);

    // R5: trigger with value other than 1
    wr("R5 ring value 3", 2'd1, 8'h00, 32'd3, 5'd9);
    wr("R5 ring value 0", 2'd1, 8'h00, 32'd0, 5'd10);
    rd("R5 raw unchanged", 2'd1, 8'h08);
    check("R5 raw literal", rsp_rdata[31:0], 32'h0000_0088);

    // R6: pending write-one-to-clear
    wr("R6 clear zero", 2'd1, 8'h0C, 32'h0, 5'd0);
    rd("R6 pend kept", 2'd1, 8'h0C);
    wr("R6 clear bit3", 2'd1, 8'h0C, 32'h8, 5'd0);
    rd("R6 pend cleared", 2'd1, 8'h0C);
    check("R6 irq low", {31'h0, irq[1]}, 32'h0);

    // R7: raw write-one-to-clear
    wr("R7 raw clear bit7", 2'd1, 8'h08, 32'h80, 5'd0);
    rd("R7 raw after clear", 2'd1, 8'h08);
    check("R7 raw literal", rsp_rdata[31:0], 32'h0000_0008);

    // R8: ring against clear in the same cycle
    wr("R8 enable bit4", 2'd3, 8'h04, 32'h10, 5'd0);
    wr("R8 first ring", 2'd3, 8'h00, 32'd1, 5'd4);
    set_port(0, 1'b1, 2'd3, 8'h0C, 32'h10, 5'd0);
    set_port(1, 1'b1, 2'd3, 8'h00, 32'd1, 5'd4);
    step("R8 pend collision");
    set_port(0, 1'b1, 2'd3, 8'h08, 32'h10, 5'd0);
    set_port(1, 1'b1, 2'd3, 8'h00, 32'd1, 5'd4);
    step("R8 raw collision");
    rd("R8 pend survives", 2'd3, 8'h0C);
    check("R8 pend literal", rsp_rdata[31:0], 32'h0000_0010);
    rd("R8 raw survives", 2'd3, 8'h08);
    check("R8 raw literal", rsp_rdata[31:0], 32'h0000_0010);

    // R11: enable collision, port 0 wins
    set_port(0, 1'b1, 2'd0, 8'h04, 32'h1, 5'd0);
    set_port(1, 1'b1, 2'd0, 8'h04, 32'h2, 5'd0);
    step("R11 enable collision");
    rd("R11 enable port0", 2'd0, 8'h04);
    check("R11 enable literal", rsp_rdata[31:0], 32'h1);

    // R12: read-before-write in the same cycle
    set_port(0, 1'b0, 2'd3, 8'h0C, 32'h0, 5'd0);
    set_port(1, 1'b1, 2'd3, 8'h0C, 32'h10, 5'd0);
    step("R12 read old pend");
    check("R12 read literal", rsp_rdata[31:0], 32'h0000_0010);
    rd("R12 pend now clear", 2'd3, 8'h0C);

    // R10: empty and misaligned offsets
    rd("R10 ring word reads 0", 2'd2, 8'h00);
    rd("R10 offset 0x10", 2'd2, 8'h10);
    rd("R10 misaligned", 2'd2, 8'h05);
    wr("R10 write unused", 2'd2, 8'h44, 32'hFFFF_FFFF, 5'd1);
    wr("R10 write misaligned", 2'd2, 8'h06, 32'h0, 5'd1);
    rd("R10 enable untouched", 2'd2, 8'h04);
    check("R10 enable literal", rsp_rdata[31:0], 32'hA5A5_0F0F);

    // Random traffic on both ports
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NP; p++) begin
        int sel;
        logic [7:0] off;
        logic [31:0] d;
        sel = int'($urandom % 10);
        case (sel)
          0, 1, 2: off = 8'h00;
          3:       off = 8'h04;
          4:       off = 8'h08;
          5, 6:    off = 8'h0C;
          7:       off = 8'(($urandom % 64) << 2);
          default: off = 8'($urandom);
        endcase
        if (off == 8'h00) d = (($urandom % 4) != 0) ? 32'd1 : $urandom;
        else              d = $urandom;
        if (($urandom % 4) != 0)
          set_port(p, 1'($urandom), 2'($urandom), off, d, 5'($urandom % NM));
      end
      step("R12 random read");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule